// File: doc/BRIEF.md
# Byte Table Lookup Unit

This block turns a word of four byte-wide indices into a word of four bytes read from a small local table. The table is a set of 64-bit registers loaded through a plain write port: a register address, a data word and a write enable. A caller presents an index word, a default word and the number of table bytes currently in use, and raises a request strobe. One clock later the block returns the translated word with a valid strobe.

Each lane is translated on its own. An index below the table byte count reads one table byte. The upper index bits pick the register and the lowest three bits pick the byte inside it. An index at or above the count does not read the table. That lane instead passes through the byte of the default word in the same lane, so several lookups can be chained, each one filling the lanes the previous one left open.

Top module: `byte_xlate_unit`

## Requirements
- R1: A synchronous active-high reset clears every table register to zero, drives `res_valid` low and clears `res_word` to zero.
- R2: A table write with `tbl_we` high stores `tbl_wdata` into register `tbl_addr` at the next rising edge. A lookup requested in the same cycle as the write still reads the old contents.
- R3: The index word holds four independent 8-bit indices at bit offsets 0, 8, 16 and 24. The index at offset 8k produces result bits [8k+7:8k] and does not affect any other lane.
- R4: An in-range index reads table register idx[7:3] and takes the byte at bits [8*idx[2:0]+7 : 8*idx[2:0]] of that register, so byte 0 is bits [7:0].
- R5: An index that is not strictly less than the effective table byte count yields, in its lane, the byte of `dflt_word` at the same bit offset.
- R6: The effective table byte count equals `tbl_count` when `tbl_count` is 8, 16, 24 or 32, meaning one to four registers. Any other value of `tbl_count`, including 0, is treated as 32.
- R7: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. `res_word` loads only on a requested cycle and otherwise holds its value.
- R8: Indices are unsigned, so any index of 32 or more (for example 0x80 or 0xFF) always yields the default byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table register write enable |
| tbl_addr | input | 2 | Table register number to write |
| tbl_wdata | input | 64 | Data written into the table register |
| tbl_count | input | 8 | Number of table bytes in use (8, 16, 24 or 32) |
| req_valid | input | 1 | Lookup request strobe |
| idx_word | input | 32 | Four packed 8-bit indices |
| dflt_word | input | 32 | Per-lane fallback bytes for out-of-range indices |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_word | output | 32 | Translated word |

## Verification
A lookup result and its valid strobe are due exactly one rising edge after the request cycle. A table write becomes visible to lookups issued from the following cycle onward. The bench drives inputs on the falling edge. Its reference model computes the expected word from the table image as it stood before that cycle's write. The bench then waits one rising edge and compares at the next falling edge. Idle cycles are compared the same way, so a result that changes when no request was made is reported.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
   localparam int unsigned XLT_LANE_W = 8;
   typedef logic [XLT_LANE_W-1:0] xlt_byte_t;
endpackage

// File: rtl/xlt_table_bank.sv
module xlt_table_bank #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned REG_W    = 64,
   localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [REG_W-1:0]          wdata,
   output logic [NUM_REGS*REG_W-1:0] flat
);
   logic [REG_W-1:0] regs_q [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            regs_q[r] <= '0;
         end else if (we && (addr == ADDR_W'(r))) begin
            regs_q[r] <= wdata;
         end
      end
      assign flat[r*REG_W +: REG_W] = regs_q[r];
   end
endmodule

// File: rtl/xlt_count_norm.sv
module xlt_count_norm #(
   parameter int unsigned NUM_REGS  = 4,
   parameter int unsigned REG_BYTES = 8,
   parameter int unsigned CNT_W     = 8
) (
   input  logic [CNT_W-1:0] count_in,
   output logic [CNT_W-1:0] limit
);
   localparam int unsigned TBL_BYTES = NUM_REGS * REG_BYTES;

   logic [NUM_REGS-1:0] hit;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_legal
      assign hit[k] = (count_in == CNT_W'((k + 1) * REG_BYTES));
   end

   always_comb begin
      limit = (|hit) ? count_in : CNT_W'(TBL_BYTES);
   end
endmodule

// File: rtl/xlt_lane_pick.sv
module xlt_lane_pick
   import xlt_pkg::*;
#(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned REG_W    = 64,
   localparam int unsigned TBL_BYTES = NUM_REGS * (REG_W / XLT_LANE_W),
   localparam int unsigned SEL_W     = $clog2(TBL_BYTES)
) (
   input  xlt_byte_t                 idx,
   input  xlt_byte_t                 dflt,
   input  xlt_byte_t                 limit,
   input  logic [NUM_REGS*REG_W-1:0] tbl_flat,
   output xlt_byte_t                 result
);
   logic [SEL_W-1:0] sel;
   xlt_byte_t        tbl_byte;
   logic             in_range;

   assign sel      = idx[SEL_W-1:0];
   assign tbl_byte = tbl_flat[sel*XLT_LANE_W +: XLT_LANE_W];
   assign in_range = (idx < limit);
   assign result   = in_range ? tbl_byte : dflt;
endmodule

// File: rtl/byte_xlate_unit.sv
module byte_xlate_unit
   import xlt_pkg::*;
#(
   parameter int unsigned LANES    = 4,
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned REG_W    = 64,
   localparam int unsigned WORD_W    = LANES * XLT_LANE_W,
   localparam int unsigned REG_BYTES = REG_W / XLT_LANE_W,
   localparam int unsigned TBL_BYTES = NUM_REGS * REG_BYTES,
   localparam int unsigned ADDR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tbl_we,
   input  logic [ADDR_W-1:0] tbl_addr,
   input  logic [REG_W-1:0]  tbl_wdata,
   input  logic [7:0]        tbl_count,
   input  logic              req_valid,
   input  logic [WORD_W-1:0] idx_word,
   input  logic [WORD_W-1:0] dflt_word,
   output logic              res_valid,
   output logic [WORD_W-1:0] res_word
);
   if (REG_W % XLT_LANE_W != 0) begin : g_bad_reg_w
      $error("REG_W must be a whole number of bytes");
   end
   if (TBL_BYTES >= (1 << XLT_LANE_W) || (TBL_BYTES & (TBL_BYTES - 1)) != 0) begin : g_bad_tbl
      $error("table byte count must be a power of two below the index range");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least one");
   end

   logic [NUM_REGS*REG_W-1:0] tbl_flat;
   xlt_byte_t                 limit;
   logic [WORD_W-1:0]         lookup_w;

   xlt_table_bank #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W)
   ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (tbl_we),
      .addr  (tbl_addr),
      .wdata (tbl_wdata),
      .flat  (tbl_flat)
   );

   xlt_count_norm #(
      .NUM_REGS  (NUM_REGS),
      .REG_BYTES (REG_BYTES),
      .CNT_W     (XLT_LANE_W)
   ) u_norm (
      .count_in (tbl_count),
      .limit    (limit)
   );

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      xlt_lane_pick #(
         .NUM_REGS (NUM_REGS),
         .REG_W    (REG_W)
      ) u_pick (
         .idx      (idx_word[ln*XLT_LANE_W +: XLT_LANE_W]),
         .dflt     (dflt_word[ln*XLT_LANE_W +: XLT_LANE_W]),
         .limit    (limit),
         .tbl_flat (tbl_flat),
         .result   (lookup_w[ln*XLT_LANE_W +: XLT_LANE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
         res_word  <= '0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            res_word <= lookup_w;
         end
      end
   end
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker #(
   parameter int unsigned LANES     = 4,
   parameter int unsigned LANE_W    = 8,
   parameter int unsigned REG_BYTES = 8,
   parameter int unsigned TBL_BYTES = 32
) (
   input logic                    clk,
   input logic                    rst,
   input logic [7:0]              tbl_count,
   input logic                    req_valid,
   input logic [LANES*LANE_W-1:0] idx_word,
   input logic [LANES*LANE_W-1:0] dflt_word,
   input logic                    res_valid,
   input logic [LANES*LANE_W-1:0] res_word
);
   assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> res_valid);

   assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !res_valid);

   assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> $stable(res_word));

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane_chk
      assert_large_index_default_R8: assert property (@(posedge clk) disable iff (rst)
         (req_valid && (idx_word[ln*LANE_W +: LANE_W] >= LANE_W'(TBL_BYTES)))
         |=> (res_word[ln*LANE_W +: LANE_W] == $past(dflt_word[ln*LANE_W +: LANE_W])));

      assert_one_reg_bound_R5: assert property (@(posedge clk) disable iff (rst)
         (req_valid && (tbl_count == 8'(REG_BYTES))
            && (idx_word[ln*LANE_W +: LANE_W] >= LANE_W'(REG_BYTES)))
         |=> (res_word[ln*LANE_W +: LANE_W] == $past(dflt_word[ln*LANE_W +: LANE_W])));
   end
endmodule

bind byte_xlate_unit xlt_checker #(
   .LANES     (LANES),
   .LANE_W    (xlt_pkg::XLT_LANE_W),
   .REG_BYTES (REG_BYTES),
   .TBL_BYTES (TBL_BYTES)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tbl_count (tbl_count),
   .req_valid (req_valid),
   .idx_word  (idx_word),
   .dflt_word (dflt_word),
   .res_valid (res_valid),
   .res_word  (res_word)
);

// File: tb/byte_xlate_unit_tb.sv
`timescale 1ns/1ps
module byte_xlate_unit_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tbl_we = 1'b0;
   logic [1:0]  tbl_addr = '0;
   logic [63:0] tbl_wdata = '0;
   logic [7:0]  tbl_count = 8'd32;
   logic        req_valid = 1'b0;
   logic [31:0] idx_word = '0;
   logic [31:0] dflt_word = '0;
   logic        res_valid;
   logic [31:0] res_word;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;

   logic [63:0] ref_tbl [4];
   logic        exp_valid = 1'b0;
   logic [31:0] exp_word = '0;

   always #2 clk = ~clk;

   byte_xlate_unit u_dut (
      .clk       (clk),
      .rst       (rst),
      .tbl_we    (tbl_we),
      .tbl_addr  (tbl_addr),
      .tbl_wdata (tbl_wdata),
      .tbl_count (tbl_count),
      .req_valid (req_valid),
      .idx_word  (idx_word),
      .dflt_word (dflt_word),
      .res_valid (res_valid),
      .res_word  (res_word)
   );

   function automatic logic [31:0] ref_lookup(input logic [31:0] iw, input logic [31:0] dw,
                                              input logic [7:0] cnt);
      int lim;
      logic [31:0] r;
      lim = (cnt == 8 || cnt == 16 || cnt == 24 || cnt == 32) ? int'(cnt) : 32;
      r = '0;
      for (int b = 0; b < 4; b++) begin
         int ix;
         ix = int'(iw[8*b +: 8]);
         if (ix < lim) r[8*b +: 8] = ref_tbl[ix / 8][8*(ix % 8) +: 8];
         else          r[8*b +: 8] = dw[8*b +: 8];
      end
      return r;
   endfunction

   task automatic compare(input string tag);
      n_vec++;
      if (res_valid !== exp_valid || res_word !== exp_word) begin
         n_bad++;
         $display("FAIL %s: valid=%0b word=%08h expected valid=%0b word=%08h",
                  tag, res_valid, res_word, exp_valid, exp_word);
      end
   endtask

   // called at a falling edge; applies one cycle of stimulus and checks its result
   task automatic step(input bit rq, input logic [31:0] iw, input logic [31:0] dw,
                       input logic [7:0] cnt, input bit we, input logic [1:0] wa,
                       input logic [63:0] wd, input string tag);
      req_valid = rq; idx_word = iw; dflt_word = dw; tbl_count = cnt;
      tbl_we = we; tbl_addr = wa; tbl_wdata = wd;
      if (rq) exp_word = ref_lookup(iw, dw, cnt);
      exp_valid = rq;
      if (we) ref_tbl[wa] = wd;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic wr(input logic [1:0] wa, input logic [63:0] wd, input string tag);
      step(1'b0, 32'h0, 32'h0, 8'd32, 1'b1, wa, wd, tag);
   endtask

   initial begin
      for (int r = 0; r < 4; r++) ref_tbl[r] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      compare("R1 reset outputs");
      step(1'b1, 32'h18100800, 32'hAABBCCDD, 8'd32, 1'b0, 2'd0, 64'h0, "R1 table cleared");

      for (int r = 0; r < 4; r++)
         wr(2'(r), 64'h0706050403020100 + 64'(r) * 64'h0808080808080808, "R2 load");
      step(1'b1, 32'h1F100801, 32'h0, 8'd32, 1'b0, 2'd0, 64'h0, "R4 identity");

      step(1'b1, 32'h00000000, 32'h0, 8'd32, 1'b1, 2'd0, 64'hF0E1D2C3B4A59687, "R2 write same cycle");
      step(1'b1, 32'h07030100, 32'h0, 8'd32, 1'b0, 2'd0, 64'h0, "R2 write visible");
      wr(2'd3, 64'h1122334455667788, "R2 load r3");
      step(1'b1, 32'h1F1E1918, 32'h0, 8'd32, 1'b0, 2'd0, 64'h0, "R4 reg3 bytes");

      step(1'b1, 32'h031F1007, 32'h0, 8'd32, 1'b0, 2'd0, 64'h0, "R3 lanes");
      step(1'b1, 32'h05050505, 32'h0, 8'd32, 1'b0, 2'd0, 64'h0, "R3 same index");
      step(1'b1, 32'h40000200, 32'h99887766, 8'd32, 1'b0, 2'd0, 64'h0, "R3 mixed lanes");

      step(1'b1, 32'h20090807, 32'hDEADBEEF, 8'd8,  1'b0, 2'd0, 64'h0, "R5 count 8");
      step(1'b1, 32'h100F0701, 32'hCAFEF00D, 8'd16, 1'b0, 2'd0, 64'h0, "R5 count 16");
      step(1'b1, 32'h18170F00, 32'h01020304, 8'd24, 1'b0, 2'd0, 64'h0, "R5 count 24");

      step(1'b1, 32'h1F171008, 32'h55555555, 8'd0,   1'b0, 2'd0, 64'h0, "R6 count 0");
      step(1'b1, 32'h1F140F08, 32'h66666666, 8'd20,  1'b0, 2'd0, 64'h0, "R6 count 20");
      step(1'b1, 32'h201F1E00, 32'h77777777, 8'd33,  1'b0, 2'd0, 64'h0, "R6 count 33");
      step(1'b1, 32'h1F1B0A02, 32'h88888888, 8'd255, 1'b0, 2'd0, 64'h0, "R6 count 255");

      step(1'b1, 32'hFF80217F, 32'h12345678, 8'd32, 1'b0, 2'd0, 64'h0, "R8 large index");
      step(1'b1, 32'hFFFFFFFF, 32'hA5A5A5A5, 8'd8,  1'b0, 2'd0, 64'h0, "R8 all ones");

      step(1'b0, 32'h01020304, 32'hFFFFFFFF, 8'd32, 1'b0, 2'd0, 64'h0, "R7 idle hold");
      step(1'b0, 32'hFFFFFFFF, 32'h00000000, 8'd8,  1'b0, 2'd0, 64'h0, "R7 idle hold");
      step(1'b1, 32'h00010203, 32'h0,        8'd32, 1'b0, 2'd0, 64'h0, "R7 resume");

      for (int i = 0; i < 300; i++) begin
         logic [7:0] c;
         logic [31:0] iw;
         case ($urandom % 6)
            0: c = 8'd8;  1: c = 8'd16; 2: c = 8'd24;
            3: c = 8'd32; 4: c = 8'($urandom); default: c = 8'd32;
         endcase
         iw = {8'($urandom % 40), 8'($urandom % 40), 8'($urandom % 40), 8'($urandom % 40)};
         step(($urandom % 4) != 0, iw, $urandom, c, ($urandom % 3) == 0,
              2'($urandom), {$urandom, $urandom}, "R4 mixed traffic");
      end

      req_valid = 1'b0; tbl_we = 1'b0;
      rst = 1'b1;
      for (int r = 0; r < 4; r++) ref_tbl[r] = '0;
      exp_valid = 1'b0; exp_word = '0;
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      compare("R1 second reset");
      step(1'b1, 32'h1F100900, 32'hFFFFFFFF, 8'd32, 1'b0, 2'd0, 64'h0, "R1 table zero after reset");

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule